// File: doc/BRIEF.md
# Card Clock Divider Control

This block derives the clock that drives a memory-card bus from the host clock (nominally 33 MHz). A register bus writes a 16-bit control word. One field of that word picks a power-of-two division ratio. A single bit bypasses the divider so that the card runs at the host rate. Another bit gates the card clock on or off. When the word is all zeros, the card clock is stopped.

Downstream command and data logic runs in the host clock domain. It uses the one-cycle strobe `card_rise`, which marks each rising card-clock edge, as its clock enable. The block never shortens a card-clock pulse. A new ratio or gate value is applied only while the card clock is low. Every divided ratio keeps an even high/low split.

Top module: `card_clk_divider`

## Requirements
- R1: A synchronous reset clears the control word to zero. While reset is applied, and afterwards until the first write, `card_clk` and `card_rise` stay low.
- R2: With bit 8 set, bit 15 clear and bits 7..0 all zero, the card clock period is 2 host cycles.
- R3: With bit 8 set and bit 15 clear, a set bit k in bits 7..0 (k = 0..7) gives a card clock period of 2^(k+2) host cycles, so the range runs from divide-by-4 to divide-by-512.
- R4: With bits 15 and 8 both set, the card clock toggles at the host clock rate, whatever bits 7..0 hold.
- R5: With bit 8 clear, the card clock is held low whatever the other bits hold. This includes bit 15 set, a set select bit, and the all-zero word.
- R6: When several of bits 7..0 are set, the lowest-numbered set bit alone sets the ratio.
- R7: For every divided ratio, the high time and the low time each equal half the period.
- R8: A write that changes the ratio or stops the clock while the card clock is high lets that high phase run to its full length. The new setting starts only after the clock has fallen, so no high pulse is shorter than a half period.
- R9: `card_rise` is high in exactly those host cycles that begin with a rising edge of `card_clk`, and low in all others. In bypass this means every host cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: [7:0] ratio select, [8] clock enable, [15] divider bypass |
| card_clk | output | 1 | Card clock |
| card_rise | output | 1 | One host-cycle strobe for each rising card-clock edge |

## Verification
The bench samples `card_clk` on both host-clock phases and measures every complete high and low run. A wrong ratio decode, an uneven split, or a swapped priority encoder therefore shows up as a run of the wrong length. The switching cases write a new ratio, and also a stop, in the middle of a long high phase. A design that applies the write at once would cut that pulse short, and the bench sees a high run shorter than 32 host cycles. Bypass is checked with the ratio bits set and with the enable bit clear: an enable gate that ignores bypass, or a bypass that lets the divider through, gives a stuck or slow clock. The strobe is compared against the rising edges the bench itself observes. An off-by-one register would place it one cycle late.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Field positions of the control word; the decoder relies on them.
  localparam int CTRL_W_DEF  = 16;
  localparam int SEL_N_DEF   = 8;
  localparam int EN_POS_DEF  = 8;
  localparam int BYP_POS_DEF = 15;

  // Number of host cycles in one half period, minus one, for divisor 2^sh (sh >= 1).
  function automatic int unsigned half_span_m1(input int unsigned sh);
    if (sh == 0) return 0;
    return (32'd1 << (sh - 1)) - 1;
  endfunction
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg #(
  parameter int CTRL_W = clkdiv_pkg::CTRL_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (wr_en) word_q <= wr_data;
  end
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter int CTRL_W  = clkdiv_pkg::CTRL_W_DEF,
  parameter int SEL_N   = clkdiv_pkg::SEL_N_DEF,
  parameter int EN_POS  = clkdiv_pkg::EN_POS_DEF,
  parameter int BYP_POS = clkdiv_pkg::BYP_POS_DEF,
  parameter int SH_W    = $clog2(SEL_N + 2)
) (
  input  logic [CTRL_W-1:0] word,
  output logic              d_run,
  output logic              d_byp,
  output logic [SH_W-1:0]   d_sh
);
  logic [SEL_N-1:0] sel;
  logic [SEL_N-1:0] win;

  assign sel   = word[SEL_N-1:0];
  assign d_run = word[EN_POS];
  assign d_byp = word[BYP_POS];

  // A select bit wins only when every lower-numbered bit is clear.
  for (genvar g = 0; g < SEL_N; g++) begin : g_win
    if (g == 0) begin : g_first
      assign win[g] = sel[g];
    end else begin : g_rest
      assign win[g] = sel[g] & ~(|sel[g-1:0]);
    end
  end

  always_comb begin
    d_sh = SH_W'(1);
    for (int k = 0; k < SEL_N; k++) begin
      if (win[k]) d_sh = SH_W'(k + 2);
    end
    if (d_byp) d_sh = '0;
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int SEL_N = clkdiv_pkg::SEL_N_DEF,
  parameter int SH_W  = $clog2(SEL_N + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            p_run,
  input  logic            p_byp,
  input  logic [SH_W-1:0] p_sh,
  output logic            div_q,
  output logic            rise_q,
  output logic            byp_on
);
  localparam int HC_W = SEL_N;

  logic            a_run, a_byp;
  logic [SH_W-1:0] a_sh;
  logic [HC_W-1:0] hc, lim;
  logic            load, divided_on;

  assign lim        = HC_W'(clkdiv_pkg::half_span_m1(32'(a_sh)));
  assign divided_on = a_run & ~a_byp;
  assign byp_on     = a_run & a_byp;
  // The active setting is replaced only while the divided clock is low.
  assign load       = ({p_run, p_byp, p_sh} != {a_run, a_byp, a_sh}) & ~div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_run  <= 1'b0;
      a_byp  <= 1'b0;
      a_sh   <= '0;
      hc     <= '0;
      div_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= a_run & a_byp;
      if (load) begin
        a_run <= p_run;
        a_byp <= p_byp;
        a_sh  <= p_sh;
        hc    <= '0;
        div_q <= 1'b0;
      end else if (divided_on) begin
        if (hc == lim) begin
          hc    <= '0;
          div_q <= ~div_q;
          if (!div_q) rise_q <= 1'b1;
        end else begin
          hc <= hc + HC_W'(1);
        end
      end else begin
        hc    <= '0;
        div_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk,
  input  logic rst,
  input  logic byp_on,
  input  logic div_q,
  output logic card_clk
);
  logic gate_n;

  // Updated on the falling host edge, so the gate opens and closes while clk is low.
  always_ff @(negedge clk) begin
    if (rst) gate_n <= 1'b0;
    else     gate_n <= byp_on;
  end

  assign card_clk = (clk & gate_n) | div_q;
endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider #(
  parameter int CTRL_W  = clkdiv_pkg::CTRL_W_DEF,
  parameter int SEL_N   = clkdiv_pkg::SEL_N_DEF,
  parameter int EN_POS  = clkdiv_pkg::EN_POS_DEF,
  parameter int BYP_POS = clkdiv_pkg::BYP_POS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              card_clk,
  output logic              card_rise
);
  localparam int SH_W = $clog2(SEL_N + 2);

  logic [CTRL_W-1:0] word_q;
  logic              p_run, p_byp;
  logic [SH_W-1:0]   p_sh;
  logic              div_lvl, byp_on;

  clkdiv_ctrl_reg #(.CTRL_W(CTRL_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .word_q(word_q)
  );

  clkdiv_decode #(
    .CTRL_W(CTRL_W), .SEL_N(SEL_N), .EN_POS(EN_POS), .BYP_POS(BYP_POS), .SH_W(SH_W)
  ) u_dec (
    .word(word_q), .d_run(p_run), .d_byp(p_byp), .d_sh(p_sh)
  );

  clkdiv_core #(.SEL_N(SEL_N), .SH_W(SH_W)) u_core (
    .clk(clk), .rst(rst), .p_run(p_run), .p_byp(p_byp), .p_sh(p_sh),
    .div_q(div_lvl), .rise_q(card_rise), .byp_on(byp_on)
  );

  clkdiv_gate u_gate (
    .clk(clk), .rst(rst), .byp_on(byp_on), .div_q(div_lvl), .card_clk(card_clk)
  );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
  parameter int CTRL_W = clkdiv_pkg::CTRL_W_DEF,
  parameter int EN_POS = clkdiv_pkg::EN_POS_DEF,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic              card_rise,
  input logic              div_lvl,
  input logic              byp_on
);
  logic             en_seen;
  logic [CNT_W-1:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_seen <= 1'b0;
      hi_len  <= '0;
    end else begin
      if (wr_en) en_seen <= wr_data[EN_POS];
      hi_len <= div_lvl ? hi_len + CNT_W'(1) : '0;
    end
  end

  // R1: reset leaves both the divided level and the strobe low
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!card_rise && !div_lvl));

  // R5: with the enable bit clear, a low card clock stays low
  p_stop_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!en_seen && !div_lvl) |=> !div_lvl);

  // R8: every completed high phase lasts a whole power-of-two number of cycles
  p_no_runt_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(div_lvl) |-> ($countones(hi_len) == 1));

  // R9: each rise of the divided clock carries the strobe
  p_rise_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(div_lvl) |-> card_rise);

  // R9: outside bypass the strobe appears only on a rise
  p_strobe_only_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (card_rise && !byp_on && !$past(byp_on)) |-> $rose(div_lvl));

  // R4: bypass and the divided path are never active together
  p_byp_excl_r4: assert property (@(posedge clk) disable iff (rst)
    byp_on |-> !div_lvl);
endmodule

bind card_clk_divider clkdiv_chk #(.CTRL_W(CTRL_W), .EN_POS(EN_POS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .card_rise(card_rise), .div_lvl(div_lvl), .byp_on(byp_on)
);

// File: tb/sim_card_clk_divider.sv
module sim_card_clk_divider;
  localparam int CLK_P = 10;
  localparam int NSMP  = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        card_clk, card_rise;

  logic smp [NSMP];
  logic rs  [NSMP];
  int nchk = 0;
  int nbad = 0;

  always #(CLK_P/2) clk = ~clk;

  card_clk_divider u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .card_clk(card_clk), .card_rise(card_rise)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [15:0] w);
    @(negedge clk); #2;
    wr_en = 1'b1; wr_data = w;
    @(negedge clk); #2;
    wr_en = 1'b0;
  endtask

  // Two samples per host cycle: just after the rising and just after the falling edge.
  task automatic capture(input int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #1;
      smp[2*c] = card_clk; rs[2*c] = card_rise;
      @(negedge clk); #1;
      smp[2*c+1] = card_clk; rs[2*c+1] = 1'b0;
    end
  endtask

  task automatic check_rise(input int ncyc, input string req);
    int bad = 0;
    int badc = 0;
    for (int c = 1; c < ncyc; c++) begin
      if (rs[2*c] !== (smp[2*c] & ~smp[2*c-1])) begin bad++; badc = c; end
    end
    check(bad == 0, req, bad, 0);
    if (bad != 0) $display("  strobe mismatch near sample cycle %0d", badc);
  endtask

  // hexp: expected length of every complete high and low run, in half-cycle samples.
  task automatic check_steady(input string req, input int hexp, input int ncyc);
    int n, i, len, nruns, bad, badv;
    logic cur;
    capture(ncyc);
    n = 2*ncyc; nruns = 0; bad = 0; badv = hexp;
    i = 1;
    while (i < n && smp[i] == smp[0]) i++;
    while (i < n) begin
      cur = smp[i]; len = 0;
      while (i < n && smp[i] == cur) begin len++; i++; end
      if (i < n) begin
        nruns++;
        if (len != hexp) begin bad++; badv = len; end
      end
    end
    check(bad == 0 && nruns >= 2, req, badv, hexp);
    check_rise(ncyc, "R9 strobe on each rising edge");
  endtask

  task automatic check_stopped(input string req, input int ncyc);
    int hi = 0;
    int st = 0;
    capture(ncyc);
    for (int i = 0; i < 2*ncyc; i++) begin
      if (smp[i] !== 1'b0) hi++;
      if (rs[i] !== 1'b0) st++;
    end
    check(hi == 0, req, hi, 0);
    check(st == 0, "R9 no strobe while stopped", st, 0);
  endtask

  task automatic t_reset;
    int bad = 0;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      if (card_clk !== 1'b0 || card_rise !== 1'b0) bad++;
    end
    @(negedge clk); rst = 1'b0;
    check(bad == 0, "R1 outputs low in reset", bad, 0);
    check_stopped("R1 clock stopped after reset", 60);
  endtask

  task automatic t_div2;
    write_ctrl(16'h0100);
    repeat (20) @(posedge clk);
    check_steady("R2 all-zero select divides by 2", 2, 40);
  endtask

  task automatic t_each_select;
    for (int k = 0; k < 8; k++) begin
      write_ctrl(16'h0100 | (16'h1 << k));
      repeat (600) @(posedge clk);
      check_steady($sformatf("R3 R7 select bit %0d ratio and duty", k),
                   1 << (k + 2), 3 * (1 << (k + 2)) + 4);
    end
  endtask

  task automatic t_priority;
    write_ctrl(16'h01A4);
    repeat (600) @(posedge clk);
    check_steady("R6 lowest set bit 2 wins over 5 and 7", 16, 80);
    write_ctrl(16'h01C0);
    repeat (600) @(posedge clk);
    check_steady("R6 lowest set bit 6 wins over 7", 256, 400);
  endtask

  task automatic t_bypass;
    write_ctrl(16'h810F);
    repeat (600) @(posedge clk);
    check_steady("R4 bypass runs at host rate", 1, 40);
    write_ctrl(16'h8000);
    repeat (20) @(posedge clk);
    check_stopped("R5 bypass without enable stays low", 60);
  endtask

  task automatic t_disable;
    write_ctrl(16'h0104);
    repeat (600) @(posedge clk);
    write_ctrl(16'h0004);
    repeat (100) @(posedge clk);
    check_stopped("R5 enable clear holds clock low", 100);
    write_ctrl(16'h0000);
    repeat (20) @(posedge clk);
    check_stopped("R5 zero word stops clock", 60);
  endtask

  // Start divide-by-64, write during a high phase, and check that the pulse in progress completes.
  task automatic t_switch(input logic [15:0] neww, input int new_h, input string req);
    int n, i, len, nruns, bad, badv, first;
    logic cur;
    write_ctrl(16'h0110);
    repeat (200) @(posedge clk);
    do begin @(posedge clk); #1; end while (card_rise !== 1'b1);
    fork
      capture(400);
      begin repeat (6) @(negedge clk); write_ctrl(neww); end
    join
    n = 800;
    i = 0;
    while (i < n && smp[i] == 1'b1) i++;
    first = i + 2;
    check(first == 64, {req, " old high phase completes"}, first, 64);
    nruns = 0; bad = 0; badv = new_h;
    while (i < n) begin
      cur = smp[i]; len = 0;
      while (i < n && smp[i] == cur) begin len++; i++; end
      if (new_h == 0) begin
        if (cur) begin bad++; badv = len; end
      end else if (i < n) begin
        if (cur) begin
          nruns++;
          if (len != new_h) begin bad++; badv = len; end
        end else if (len < new_h) begin
          bad++; badv = len;
        end
      end
    end
    check(bad == 0 && (new_h == 0 || nruns >= 2), {req, " new setting clean"}, badv, new_h);
    check_rise(400, "R9 strobe across switch");
  endtask

  initial begin
    #(CLK_P * 190000);
    nbad++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_div2();
    t_each_select();
    t_priority();
    t_bypass();
    t_disable();
    t_switch(16'h0101, 4, "R8 ratio change mid-high");
    t_switch(16'h0000, 0, "R8 stop mid-high");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule